// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Start Lock

This block keeps the wall-clock time and the calendar as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-pulse-per-second tick from an external divider advances the seconds. Carries ripple through minutes, hours and the date fields within the same clock edge. Month lengths and the leap-year rule for the years 2000 to 2099 decide when the day of month wraps. A control bit picks either 24-hour counting or 12-hour counting with a PM flag.

Software loads any field through a simple write port and reads any field back through a registered read port. Each load of a time field also emits a one-cycle pulse, which the divider uses to restart its sub-second phase. The next tick therefore lands one full second after the load.

Reset stands for power returning after a complete loss of supply. After reset the counter is frozen and a sticky failure flag is raised. The counter stays frozen until software loads at least one time field. Software clears the flag by writing it to zero.

Top module: `bcd_rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0x00, day 0x01, month 0x01 and year 0x00. The control register reads 0x03, which means 24-hour mode with the failure flag set.
- R2: Address map: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year, 7 control. Seconds and minutes count 0x00..0x59 in BCD, and each accepted tick adds one second. A wrap from 0x59 to 0x00 carries into the next field on the same edge.
- R3: In 24-hour mode (control bit 0 = 1) the hours count 0x00..0x23. The step from 23:59:59 to 00:00:00 advances the date fields.
- R4: In 12-hour mode (control bit 0 = 0), hour bits 4:0 hold BCD 01..12 and bit 5 is the PM flag. The hour runs 12, 01, ..., 11, 12, and PM toggles on the step from 11 to 12. The date advances only on the step from 11 PM to 12 AM. Changing bit 0 does not convert the stored hour.
- R5: The day of month wraps to 0x01 after day 30 in April, June, September and November, after day 28 in a common-year February, and after day 31 in every other month. Month 0x12 wraps to 0x01 and increments the year, and year 0x99 wraps to 0x00.
- R6: A year whose value is divisible by 4, including 0x00, gives February 29 days.
- R7: The weekday counts 0..6, wraps from 6 to 0, and advances on the same edge as the day of month.
- R8: From reset, ticks have no effect until a write to any address 0..6. A write to address 7 does not release the lock.
- R9: The failure flag is control bit 1. Reset sets it. Writing 0 to bit 1 clears it, and writing 1 leaves it unchanged.
- R10: A write stores the data masked to the field width: seconds and minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x1F, year 0xFF. When a time-field write and a tick fall in the same cycle, the write wins and the tick is dropped.
- R11: `sub_sec_clr` is high for exactly the cycle after each write to addresses 0..6, and low otherwise.
- R12: `rd_data` shows the register selected by `rd_addr` on the previous clock edge, as it stood before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; stands for power returning after total loss |
| tick_1hz | input | 1 | One-cycle pulse per second from the divider |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| sub_sec_clr | output | 1 | Pulse that restarts the divider's sub-second phase |

## Verification
The bench builds the block with its default parameters: seven counted fields and a three-bit address. No field width is sized by a parameter, so every rollover is reached by loading values just short of a boundary, such as 11 PM 59:59 on a month's last day, and then giving one or two ticks. The bench ticks every other clock while writes land freely, so loads that coincide with a tick happen often. The bench also sweeps month ends in a common year, a leap year, year 00 and year 99.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam int FLD_W  = 8;

  typedef logic [FLD_W-1:0] bcd8_t;

  typedef enum logic [ADDR_W-1:0] {
    ADR_SEC  = 3'd0,
    ADR_MIN  = 3'd1,
    ADR_HOUR = 3'd2,
    ADR_WDAY = 3'd3,
    ADR_DATE = 3'd4,
    ADR_MON  = 3'd5,
    ADR_YEAR = 3'd6,
    ADR_CTL  = 3'd7
  } rtc_addr_e;

  // Two-digit BCD increment; tens digit simply grows
  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Leap rule for a two-digit year in 2000..2099
  function automatic logic bcd_leap(input bcd8_t y);
    logic [7:0] b;
    b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  // Last day of a month in BCD
  function automatic bcd8_t bcd_month_end(input bcd8_t m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_field_ctr.sv
// Generic wrapping BCD field with load priority over increment.
module rtc_field_ctr
  import rtc_pkg::*;
#(
  parameter logic [7:0] LO   = 8'h00,
  parameter logic [7:0] HI   = 8'h59,
  parameter logic [7:0] MASK = 8'h7F,
  parameter logic [7:0] RST  = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o
);
  always_ff @(posedge clk) begin
    if (rst)        val_o <= RST;
    else if (ld_i)  val_o <= ld_val_i & MASK;
    else if (inc_i) val_o <= (val_o == HI) ? LO : bcd_inc(val_o);
  end
endmodule

// File: rtl/rtc_hour_ctr.sv
// Hour field: 24-hour BCD or 12-hour BCD with PM flag in bit 5.
module rtc_hour_ctr
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fmt24_i,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o,
  output logic       day_o
);
  localparam logic [7:0] HMASK = 8'h3F;

  logic [7:0] nxt;
  logic [7:0] inc12;
  logic       wrap;

  assign inc12 = bcd_inc({3'b000, val_o[4:0]});

  always_comb begin
    nxt  = val_o;
    wrap = 1'b0;
    if (fmt24_i) begin
      if (val_o == 8'h23) begin
        nxt  = 8'h00;
        wrap = 1'b1;
      end else begin
        nxt = bcd_inc(val_o);
      end
    end else begin
      if (val_o[4:0] == 5'h12) begin
        nxt = {2'b00, val_o[5], 5'h01};
      end else if (val_o[4:0] == 5'h11) begin
        nxt  = {2'b00, ~val_o[5], 5'h12};
        wrap = val_o[5];
      end else begin
        nxt = {2'b00, val_o[5], inc12[4:0]};
      end
    end
  end

  assign day_o = inc_i & wrap;

  always_ff @(posedge clk) begin
    if (rst)        val_o <= 8'h00;
    else if (ld_i)  val_o <= ld_val_i & HMASK;
    else if (inc_i) val_o <= nxt;
  end
endmodule

// File: rtl/rtc_cal_ctr.sv
// Weekday, day of month, month and year with month-length and leap rules.
module rtc_cal_ctr
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_inc_i,
  input  logic [3:0] ld_i,       // {year, month, date, weekday}
  input  logic [7:0] ld_val_i,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  localparam logic [7:0] DMASK = 8'h3F;

  logic [7:0] last_day;
  logic       date_wrap;
  logic       mon_wrap;

  assign last_day  = bcd_month_end(mon_o, bcd_leap(year_o));
  assign date_wrap = day_inc_i && (date_o == last_day);
  assign mon_wrap  = date_wrap && (mon_o == 8'h12);

  rtc_field_ctr #(.LO(8'h00), .HI(8'h06), .MASK(8'h07), .RST(8'h00)) u_wday (
    .clk(clk), .rst(rst), .inc_i(day_inc_i), .ld_i(ld_i[0]),
    .ld_val_i(ld_val_i), .val_o(wday_o)
  );

  always_ff @(posedge clk) begin
    if (rst)            date_o <= 8'h01;
    else if (ld_i[1])   date_o <= ld_val_i & DMASK;
    else if (day_inc_i) date_o <= date_wrap ? 8'h01 : bcd_inc(date_o);
  end

  rtc_field_ctr #(.LO(8'h01), .HI(8'h12), .MASK(8'h1F), .RST(8'h01)) u_mon (
    .clk(clk), .rst(rst), .inc_i(date_wrap), .ld_i(ld_i[2]),
    .ld_val_i(ld_val_i), .val_o(mon_o)
  );

  rtc_field_ctr #(.LO(8'h00), .HI(8'h99), .MASK(8'hFF), .RST(8'h00)) u_year (
    .clk(clk), .rst(rst), .inc_i(mon_wrap), .ld_i(ld_i[3]),
    .ld_val_i(ld_val_i), .val_o(year_o)
  );
endmodule

// File: rtl/rtc_ctl.sv
// Write decode, start lock, failure flag, format bit and phase-restart pulse.
module rtc_ctl
  import rtc_pkg::*;
#(
  parameter int NFLD = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [1:0]        ctl_bits_i,
  output logic              adv_o,
  output logic              fmt24_o,
  output logic              fail_o,
  output logic              run_o,
  output logic              clr_o,
  output logic [NFLD-1:0]   ld_o
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NFLD);

  logic ctl_wr;
  logic time_wr;

  assign ctl_wr  = wr_en_i && (wr_addr_i == CTL_ADDR);
  assign time_wr = wr_en_i && !ctl_wr;

  for (genvar i = 0; i < NFLD; i++) begin : g_dec
    assign ld_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  // A time write restarts the second, so a coincident tick is dropped
  assign adv_o = tick_i && run_o && !time_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o   <= 1'b0;
      fail_o  <= 1'b1;
      fmt24_o <= 1'b1;
      clr_o   <= 1'b0;
    end else begin
      clr_o <= time_wr;
      if (time_wr) run_o <= 1'b1;
      if (ctl_wr) begin
        fmt24_o <= ctl_bits_i[0];
        if (!ctl_bits_i[1]) fail_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_calendar.sv
module bcd_rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              sub_sec_clr
);
  localparam int NFLD = (1 << ADDR_W) - 1;

  logic            adv, fmt24_q, fail_q, run_q;
  logic [NFLD-1:0] fld_ld;
  logic [7:0]      sec_q, min_q, hour_q, wday_q, date_q, mon_q, year_q;
  logic            sec_wrap, min_wrap, day_inc;

  rtc_ctl #(.NFLD(NFLD)) u_ctl (
    .clk(clk), .rst(rst), .tick_i(tick_1hz), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .ctl_bits_i(wr_data[1:0]),
    .adv_o(adv), .fmt24_o(fmt24_q), .fail_o(fail_q), .run_o(run_q),
    .clr_o(sub_sec_clr), .ld_o(fld_ld)
  );

  assign sec_wrap = adv && (sec_q == 8'h59);
  assign min_wrap = sec_wrap && (min_q == 8'h59);

  rtc_field_ctr #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F), .RST(8'h00)) u_sec (
    .clk(clk), .rst(rst), .inc_i(adv), .ld_i(fld_ld[ADR_SEC]),
    .ld_val_i(wr_data), .val_o(sec_q)
  );

  rtc_field_ctr #(.LO(8'h00), .HI(8'h59), .MASK(8'h7F), .RST(8'h00)) u_min (
    .clk(clk), .rst(rst), .inc_i(sec_wrap), .ld_i(fld_ld[ADR_MIN]),
    .ld_val_i(wr_data), .val_o(min_q)
  );

  rtc_hour_ctr u_hour (
    .clk(clk), .rst(rst), .fmt24_i(fmt24_q), .inc_i(min_wrap),
    .ld_i(fld_ld[ADR_HOUR]), .ld_val_i(wr_data), .val_o(hour_q),
    .day_o(day_inc)
  );

  rtc_cal_ctr u_cal (
    .clk(clk), .rst(rst), .day_inc_i(day_inc),
    .ld_i(fld_ld[ADR_YEAR:ADR_WDAY]), .ld_val_i(wr_data),
    .wday_o(wday_q), .date_o(date_q), .mon_o(mon_q), .year_o(year_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADR_SEC:  rd_data <= sec_q;
        ADR_MIN:  rd_data <= min_q;
        ADR_HOUR: rd_data <= hour_q;
        ADR_WDAY: rd_data <= wday_q;
        ADR_DATE: rd_data <= date_q;
        ADR_MON:  rd_data <= mon_q;
        ADR_YEAR: rd_data <= year_q;
        default:  rd_data <= {6'd0, fail_q, fmt24_q};
      endcase
    end
  end
endmodule

// File: rtl/bcd_rtc_calendar_chk.sv
module bcd_rtc_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       sub_sec_clr,
  input logic       run,
  input logic       fail,
  input logic       fmt24,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date
);
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !wr_en && sec == 8'h59) |=> (sec == 8'h00));

  a_r3_midnight: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !wr_en && fmt24 && hour == 8'h23 && min == 8'h59 && sec == 8'h59)
    |=> (hour == 8'h00 && date != $past(date)));

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && wr_addr != 3'd7)) |=> ($stable(sec) && $stable(hour)));

  a_r8_unlock: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != 3'd7) |=> run);

  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    !fail |=> !fail);

  a_r10_sec_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0) |=> (sec == ($past(wr_data) & 8'h7F)));

  a_r11_clr_after_wr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != 3'd7) |=> sub_sec_clr);

  a_r11_clr_quiet: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr != 3'd7) |=> !sub_sec_clr);
endmodule

bind bcd_rtc_calendar bcd_rtc_calendar_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick_1hz), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sub_sec_clr(sub_sec_clr), .run(run_q), .fail(fail_q),
  .fmt24(fmt24_q), .sec(sec_q), .min(min_q), .hour(hour_q), .date(date_q)
);

// File: tb/bcd_rtc_calendar_test.sv
module bcd_rtc_calendar_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic       sub_sec_clr;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    tick_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1 reset state";

  always #4 clk = ~clk;

  bcd_rtc_calendar uut (
    .clk(clk), .rst(rst), .tick_1hz(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sub_sec_clr(sub_sec_clr)
  );

  // ---------------- behavioural reference model ----------------
  int         m_sec = 0, m_min = 0, m_wday = 0, m_date = 1, m_mon = 1, m_year = 0;
  logic [7:0] m_hour = 8'h00;
  bit         m_run = 0, m_fail = 1, m_fmt24 = 1;
  logic [7:0] exp_rd = 8'h00;
  logic [2:0] exp_addr = 3'd0;
  bit         exp_clr = 0;

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    case (mo)
      2: return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return i2b(m_sec);
      3'd1: return i2b(m_min);
      3'd2: return m_hour;
      3'd3: return 8'(m_wday);
      3'd4: return i2b(m_date);
      3'd5: return i2b(m_mon);
      3'd6: return i2b(m_year);
      default: return {6'd0, m_fail, m_fmt24};
    endcase
  endfunction

  always @(posedge clk) begin
    bit tw, adv, day, pm;
    int h;
    if (rst) begin
      m_sec = 0; m_min = 0; m_hour = 8'h00; m_wday = 0; m_date = 1; m_mon = 1; m_year = 0;
      m_run = 0; m_fail = 1; m_fmt24 = 1; exp_rd = 8'h00; exp_clr = 0; exp_addr = rd_addr;
    end else begin
      exp_rd   = m_read(rd_addr);
      exp_addr = rd_addr;
      tw       = wr_en && (wr_addr != 3'd7);
      exp_clr  = tw;
      adv      = tick && m_run && !tw;
      day      = 0;
      if (adv) begin
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0;
          m_min++;
          if (m_min == 60) begin
            m_min = 0;
            if (m_fmt24) begin
              h = b2i(m_hour & 8'h3F) + 1;
              if (h == 24) begin h = 0; day = 1; end
              m_hour = i2b(h);
            end else begin
              h  = b2i(m_hour & 8'h1F);
              pm = m_hour[5];
              if (h == 12) h = 1;
              else if (h == 11) begin h = 12; if (pm) day = 1; pm = !pm; end
              else h++;
              m_hour = i2b(h) | (pm ? 8'h20 : 8'h00);
            end
          end
        end
        if (day) begin
          m_wday = (m_wday + 1) % 7;
          m_date++;
          if (m_date > mdays(m_mon, m_year)) begin
            m_date = 1;
            m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
          end
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_sec  = b2i(wr_data & 8'h7F);
          3'd1: m_min  = b2i(wr_data & 8'h7F);
          3'd2: m_hour = wr_data & 8'h3F;
          3'd3: m_wday = int'(wr_data & 8'h07);
          3'd4: m_date = b2i(wr_data & 8'h3F);
          3'd5: m_mon  = b2i(wr_data & 8'h1F);
          3'd6: m_year = b2i(wr_data);
          default: begin
            m_fmt24 = wr_data[0];
            if (!wr_data[1]) m_fail = 0;
          end
        endcase
      end
      if (tw) m_run = 1;
    end
  end

  // ---------------- stimulus helpers ----------------
  always @(negedge clk) rd_addr <= rd_addr + 3'd1;
  always @(negedge clk) tick <= tick_on ? !tick : 1'b0;

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL [%s] %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // R12 read data and R11 phase pulse compared every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      check($sformatf("R12 read addr %0d", exp_addr), rd_data, exp_rd);
      check("R11 sub_sec_clr", {7'd0, sub_sec_clr}, {7'd0, exp_clr});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Constant expectation read through the normal read port
  task automatic peek(input logic [2:0] a, input logic [7:0] e, input string tag);
    do @(negedge clk); while (exp_addr != a);
    check(tag, rd_data, e);
  endtask

  // Load 11 PM 59:59 on the given date, then let one or two ticks through
  task automatic roll(input int mo, input int yr, input int dt);
    tick_on = 0;
    wr(3'd5, i2b(mo)); wr(3'd6, i2b(yr)); wr(3'd4, i2b(dt));
    wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tick_on = 1;
    repeat (3) @(negedge clk);
    tick_on = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    phase = "R1 reset state, R8 frozen";
    tick_on = 1;
    repeat (40) @(negedge clk);
    peek(3'd0, 8'h00, "R1 seconds");
    peek(3'd2, 8'h00, "R1 hours");
    peek(3'd4, 8'h01, "R1 day of month");
    peek(3'd5, 8'h01, "R1 month");
    peek(3'd7, 8'h03, "R1 control, R9 flag set");

    phase = "R8 control write keeps lock";
    wr(3'd7, 8'h03);
    repeat (20) @(negedge clk);
    peek(3'd0, 8'h00, "R8 still frozen");

    phase = "R9 failure flag";
    wr(3'd7, 8'h01);
    wr(3'd7, 8'h03);
    peek(3'd7, 8'h01, "R9 cleared by 0, not set by 1");

    phase = "R8 unlock, R2 seconds and minutes, R10 write vs tick";
    wr(3'd0, 8'h45);
    repeat (200) @(negedge clk);
    for (int i = 0; i < 12; i++) wr(3'd0, i2b(i * 5));
    repeat (30) @(negedge clk);

    phase = "R3 midnight, R7 weekday";
    tick_on = 0;
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    wr(3'd3, 8'h06); wr(3'd4, 8'h15);
    tick_on = 1;
    repeat (8) @(negedge clk);
    tick_on = 0;
    peek(3'd2, 8'h00, "R3 23 to 00");
    peek(3'd4, 8'h16, "R3 date advanced");
    peek(3'd3, 8'h00, "R7 weekday 6 to 0");

    phase = "R4 12-hour mode";
    wr(3'd7, 8'h00);
    wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59); wr(3'd3, 8'h02);
    tick_on = 1; repeat (4) @(negedge clk); tick_on = 0;
    peek(3'd2, 8'h12, "R4 11 PM to 12 AM");
    peek(3'd3, 8'h03, "R7 weekday with date");
    wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tick_on = 1; repeat (4) @(negedge clk); tick_on = 0;
    peek(3'd2, 8'h32, "R4 11 AM to 12 PM");
    wr(3'd2, 8'h32); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tick_on = 1; repeat (4) @(negedge clk); tick_on = 0;
    peek(3'd2, 8'h21, "R4 12 to 1 keeps PM");

    phase = "R5 month ends";
    roll(2, 23, 28);
    peek(3'd4, 8'h01, "R5 common February wraps after 28");
    peek(3'd5, 8'h03, "R5 March follows");
    roll(4, 23, 30);
    peek(3'd5, 8'h05, "R5 30-day month");
    roll(12, 99, 31);
    peek(3'd6, 8'h00, "R5 year 99 to 00");
    peek(3'd5, 8'h01, "R5 December to January");

    phase = "R6 leap years";
    roll(2, 24, 28);
    peek(3'd4, 8'h29, "R6 leap February reaches 29");
    roll(2, 0, 28);
    peek(3'd4, 8'h29, "R6 year 00 is leap");

    phase = "R5 R6 month sweep";
    for (int y = 0; y < 4; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        roll(mo, (y == 0) ? 23 : (y == 1) ? 24 : (y == 2) ? 0 : 99,
             mdays(mo, (y == 0) ? 23 : (y == 1) ? 24 : (y == 2) ? 0 : 99));
      end
    end

    phase = "R10 field masks";
    wr(3'd3, 8'hFF);
    peek(3'd3, 8'h07, "R10 weekday mask");
    wr(3'd5, 8'hF2);
    peek(3'd5, 8'h12, "R10 month mask");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule